// File: doc/BRIEF.md
# Wrapping Microcode Return Stack

This block is a last-in first-out store of 96 words of 16 bits that a microsequencer uses for subroutine return addresses and as a save area for its 16-bit memory pointer. A call pushes a return address. A return pops the newest word, which the surrounding logic loads into either the instruction counter or the memory pointer. The block provides only the storage, the stack pointer and a small offset adder. Instruction decoding, instruction-counter sequencing and memory access belong to the surrounding logic.

The newest word is always visible on `top_o`. A pop therefore returns the value shown on `top_o` in the cycle the pop is requested, and removes that value at the clock edge. A push can add a signed offset of -3 to +3 to the value before it is stored. This lets a memory-pointer value advance or step back as it is saved.

The stack pointer counts modulo 96 and has no error signalling. Pushing more than 96 words silently overwrites the oldest word. Popping an empty stack wraps the pointer to the top of the store.

Top module: `wrap_ret_stack`

## Requirements
- R1: When `rst_n` is low at a clock edge, the stack pointer becomes 0. After reset, the first pushed word appears on `top_o` one clock after the push edge.
- R2: With `adj_en_i` low, a push stores `push_data_i` unchanged. After that edge, `top_o` shows the stored word.
- R3: Successive pops present the stored words on `top_o` in the reverse of their push order.
- R4: The pointer advances 0 to 95 and wraps from 95 to 0 on a push. A 97th push overwrites the oldest word without any error indication. The following 96 pops return the 96 newest words. One further pop returns the newest word again.
- R5: A pop at pointer 0 wraps the pointer to 95. After 96 pushes followed by 97 pops, `top_o` shows the second-newest of the 96 words.
- R6: With `adj_en_i` high, offset codes 3'b001, 3'b010 and 3'b011 add +1, +2 and +3 to the pushed value before it is stored.
- R7: With `adj_en_i` high, codes 3'b000 and 3'b100 store the value unchanged. Codes 3'b101, 3'b110 and 3'b111 add -1, -2 and -3.
- R8: With `adj_en_i` low, `adj_code_i` has no effect on the stored word.
- R9: The offset addition is modulo 2^16. 16'hFFFF with +2 stores 16'h0001, and 16'h0000 with -3 stores 16'hFFFD.
- R10: When push and pop are requested in the same cycle, only the push takes effect.
- R11: In a cycle with neither push nor pop, the pointer and `top_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request |
| push_data_i | input | 16 | Word to push (return address or memory pointer) |
| adj_en_i | input | 1 | Apply the offset code to the pushed word |
| adj_code_i | input | 3 | Offset code: bit 2 gives the sign, bits 1:0 give the magnitude |
| pop_i | input | 1 | Pop request; the popped value is `top_o` in the same cycle |
| top_o | output | 16 | Newest stored word |

## Verification
A stack pointer that is wrong by one entry shows on `top_o` in the very next cycle after any push or pop. In that case the port presents a neighbouring word instead of the one just pushed, or the previous word during a pop sequence. A pointer that wraps at the wrong count stays hidden until nesting crosses the 96-entry boundary. The wrap and underflow tests therefore fill the whole store and read it back, so that an early or late wrap surfaces as a mismatched word within one pass of 96 pops. An offset decoding fault shows on `top_o` one clock after the affected push.

// File: rtl/wrap_stack_pkg.sv
// Package: shared default sizes for the wrapping return stack.
// Assumes: a depth that is not a power of two is legal; the offset code is 3 bits.
package wrap_stack_pkg;
    localparam int STK_DEPTH = 96;
    localparam int STK_WIDTH = 16;
    localparam int ADJ_W     = 3;
endpackage

// File: rtl/wrap_ptr.sv
// Module: wrap_ptr
// Holds the stack pointer, which is the index of the next free slot, and counts modulo DEPTH.
// It also gives the index of the newest entry, (ptr - 1) mod DEPTH.
// Assumes: inc and dec are never both high (the top module resolves that case).
module wrap_ptr #(
    parameter int DEPTH = 96,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] top_idx_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    // Next values for both directions, each wrapping at the ends of the range
    always_comb begin
        ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end

    // Pointer register with synchronous reset to slot 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (inc_i)
            ptr_q <= ptr_up;
        else if (dec_i)
            ptr_q <= ptr_dn;
    end

    assign ptr_o     = ptr_q;
    assign top_idx_o = ptr_dn;
endmodule

// File: rtl/ptr_offset_adder.sv
// Module: ptr_offset_adder
// Adds a signed offset of -3..+3, written as sign and magnitude, to a word modulo 2^WIDTH.
// Code bit 2 selects subtraction and bits 1:0 give the magnitude, so 000 and 100 mean no change.
// Assumes: WIDTH >= 2.
module ptr_offset_adder #(
    parameter int WIDTH = 16,
    parameter int ADJ_W = 3
) (
    input  logic             en_i,
    input  logic [ADJ_W-1:0] code_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] mag;

    // Widen the magnitude bits; a disabled adjust forces a zero offset
    always_comb mag = en_i ? WIDTH'(code_i[ADJ_W-2:0]) : '0;

    // Apply the offset in the direction the sign bit selects, wrapping naturally
    always_comb data_o = code_i[ADJ_W-1] ? (data_i - mag) : (data_i + mag);
endmodule

// File: rtl/stack_mem.sv
// Module: stack_mem
// Register-array storage with one write port and one asynchronous read port.
// Assumes: contents are undefined until written; there is no reset on the array.
module stack_mem #(
    parameter int DEPTH = 96,
    parameter int WIDTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write the addressed slot when enabled
    always_ff @(posedge clk) begin
        if (we_i)
            mem[waddr_i] <= wdata_i;
    end

    // Combinational read of the addressed slot
    always_comb rdata_o = mem[raddr_i];
endmodule

// File: rtl/wrap_ret_stack.sv
// Module: wrap_ret_stack (top)
// A LIFO of DEPTH words whose pointer wraps modulo DEPTH, with no overflow or underflow error.
// top_o always shows the newest word; a pop returns it and removes it at the clock edge.
// A push may add a -3..+3 offset to the word on the way in.
// Assumes: push and pop in the same cycle are not intended; the push is taken and the pop is dropped.
module wrap_ret_stack
    import wrap_stack_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int WIDTH = STK_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             adj_en_i,
    input  logic [ADJ_W-1:0] adj_code_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] top_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] top_idx;
    logic [WIDTH-1:0] wr_word;
    logic             pop_take;

    // Push has priority: a pop requested together with a push is dropped
    always_comb pop_take = pop_i & ~push_i;

    wrap_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (push_i),
        .dec_i     (pop_take),
        .ptr_o     (sp_q),
        .top_idx_o (top_idx)
    );

    ptr_offset_adder #(.WIDTH(WIDTH), .ADJ_W(ADJ_W)) u_adj (
        .en_i   (adj_en_i),
        .code_i (adj_code_i),
        .data_i (push_data_i),
        .data_o (wr_word)
    );

    stack_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_mem (
        .clk     (clk),
        .we_i    (push_i),
        .waddr_i (sp_q),
        .wdata_i (wr_word),
        .raddr_i (top_idx),
        .rdata_o (top_o)
    );
endmodule

// File: rtl/wrap_ret_stack_chk.sv
// Module: wrap_ret_stack_chk
// Property checker bound to wrap_ret_stack. It checks pointer motion and wrap, push priority,
// stored words and idle stability, using an offset model written independently of the RTL adder.
// Assumes: bound with the top's parameters and its internal stack pointer.
module wrap_ret_stack_chk #(
    parameter int DEPTH = 96,
    parameter int WIDTH = 16,
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic [WIDTH-1:0] push_data_i,
    input logic             adj_en_i,
    input logic [2:0]       adj_code_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] top_o,
    input logic [PTR_W-1:0] sp
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] exp_word;

    // Expected stored word from a table of signed offsets per code
    always_comb begin
        case (adj_code_i)
            3'd1:    exp_word = push_data_i + WIDTH'(1);
            3'd2:    exp_word = push_data_i + WIDTH'(2);
            3'd3:    exp_word = push_data_i + WIDTH'(3);
            3'd5:    exp_word = push_data_i + {WIDTH{1'b1}};
            3'd6:    exp_word = push_data_i + {{(WIDTH-1){1'b1}}, 1'b0};
            3'd7:    exp_word = push_data_i + {{(WIDTH-2){1'b1}}, 2'b01};
            default: exp_word = push_data_i;
        endcase
        if (!adj_en_i)
            exp_word = push_data_i;
    end

    assert_reset_ptr_R1: assert property (@(posedge clk)
        !rst_n |=> sp == '0);

    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= LAST);

    assert_push_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> sp == (($past(sp) == LAST) ? '0 : $past(sp) + 1'b1));

    assert_pop_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> sp == (($past(sp) == '0) ? LAST : $past(sp) - 1'b1));

    assert_push_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> top_o == $past(exp_word));

    assert_plain_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !adj_en_i) |=> top_o == $past(push_data_i));

    assert_adj_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && adj_en_i) |=> top_o == $past(exp_word));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> ($stable(sp) && $stable(top_o)));
endmodule

bind wrap_ret_stack wrap_ret_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .adj_en_i    (adj_en_i),
    .adj_code_i  (adj_code_i),
    .pop_i       (pop_i),
    .top_o       (top_o),
    .sp          (sp_q)
);

// File: tb/tb_wrap_ret_stack.sv
`timescale 1ns/1ps
// Directed bench for wrap_ret_stack: one task per scenario, each checking its own results.
module tb_wrap_ret_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [15:0] push_data_i = '0;
    logic        adj_en_i = 1'b0;
    logic [2:0]  adj_code_i = '0;
    logic        pop_i = 1'b0;
    logic [15:0] top_o;

    int n_checks = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    wrap_ret_stack dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .adj_en_i(adj_en_i), .adj_code_i(adj_code_i), .pop_i(pop_i), .top_o(top_o)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected stored word from the requirement text (sign bit 2, magnitude bits 1:0)
    function automatic logic [15:0] adj_model(logic [15:0] d, logic en, logic [2:0] c);
        if (!en) return d;
        return c[2] ? d - 16'(c[1:0]) : d + 16'(c[1:0]);
    endfunction

    // One clock cycle with the given request; inputs return to idle 1 ns after the edge
    task automatic cyc(logic p, logic q, logic [15:0] d, logic e, logic [2:0] c);
        push_i = p; pop_i = q; push_data_i = d; adj_en_i = e; adj_code_i = c;
        @(posedge clk); #1;
        push_i = 0; pop_i = 0; adj_en_i = 0; adj_code_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic t_reset_first_push();
        do_reset();
        cyc(1, 0, 16'h1234, 0, 3'd0);
        check("R1 first push after reset", top_o, 16'h1234);
    endtask

    task automatic t_lifo();
        cyc(1, 0, 16'hA001, 0, 3'd0); check("R2 push A", top_o, 16'hA001);
        cyc(1, 0, 16'hA002, 0, 3'd0); check("R2 push B", top_o, 16'hA002);
        cyc(1, 0, 16'hA003, 0, 3'd0); check("R2 push C", top_o, 16'hA003);
        cyc(0, 1, 16'h0, 0, 3'd0);    check("R3 pop to B", top_o, 16'hA002);
        cyc(0, 1, 16'h0, 0, 3'd0);    check("R3 pop to A", top_o, 16'hA001);
        cyc(0, 1, 16'h0, 0, 3'd0);
    endtask

    task automatic t_offsets();
        for (int c = 0; c < 8; c++) begin
            logic [15:0] e;
            e = adj_model(16'h1000, 1'b1, 3'(c));
            cyc(1, 0, 16'h1000, 1, 3'(c));
            if (c >= 1 && c <= 3) check("R6 positive offset", top_o, e);
            else                  check("R7 zero or negative offset", top_o, e);
        end
        for (int c = 7; c >= 1; c--) begin
            cyc(0, 1, 16'h0, 0, 3'd0);
            check("R3 pop adjusted words", top_o, adj_model(16'h1000, 1'b1, 3'(c - 1)));
        end
        cyc(0, 1, 16'h0, 0, 3'd0);
        cyc(1, 0, 16'h2000, 0, 3'd3); check("R8 code ignored when disabled", top_o, 16'h2000);
        cyc(1, 0, 16'h2000, 0, 3'd7); check("R8 code ignored when disabled", top_o, 16'h2000);
        cyc(1, 0, 16'hFFFF, 1, 3'd2); check("R9 wrap up", top_o, 16'h0001);
        cyc(1, 0, 16'h0000, 1, 3'd7); check("R9 wrap down", top_o, 16'hFFFD);
        repeat (4) cyc(0, 1, 16'h0, 0, 3'd0);
    endtask

    task automatic t_push_pop_same();
        cyc(1, 0, 16'hB001, 0, 3'd0);
        cyc(1, 1, 16'hB002, 0, 3'd0); check("R10 push wins", top_o, 16'hB002);
        cyc(0, 1, 16'h0, 0, 3'd0);    check("R10 earlier word kept", top_o, 16'hB001);
        cyc(0, 1, 16'h0, 0, 3'd0);
    endtask

    task automatic t_idle();
        cyc(1, 0, 16'hC0DE, 0, 3'd0);
        repeat (3) cyc(0, 0, 16'h5555, 1, 3'd3);
        check("R11 idle holds top", top_o, 16'hC0DE);
        cyc(1, 0, 16'hC0DF, 0, 3'd0);
        cyc(0, 1, 16'h0, 0, 3'd0);
        check("R11 idle kept pointer", top_o, 16'hC0DE);
        cyc(0, 1, 16'h0, 0, 3'd0);
    endtask

    task automatic t_overflow_wrap();
        do_reset();
        for (int i = 0; i < 97; i++) cyc(1, 0, 16'h4000 + 16'(i), 0, 3'd0);
        check("R4 newest after 97 pushes", top_o, 16'h4060);
        for (int i = 96; i >= 1; i--) begin
            check("R4 pop order after overflow", top_o, 16'h4000 + 16'(i));
            cyc(0, 1, 16'h0, 0, 3'd0);
        end
        check("R4 oldest overwritten, newest again", top_o, 16'h4060);
    endtask

    task automatic t_underflow_wrap();
        do_reset();
        for (int i = 0; i < 96; i++) cyc(1, 0, 16'h7000 + 16'(i), 0, 3'd0);
        for (int i = 0; i < 97; i++) cyc(0, 1, 16'h0, 0, 3'd0);
        check("R5 pop below zero wraps to 95", top_o, 16'h705E);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset_first_push();
        t_lifo();
        t_offsets();
        t_push_pop_same();
        t_idle();
        t_overflow_wrap();
        t_underflow_wrap();
        report();
    end
endmodule